// File: doc/BRIEF.md
# Register-Topped Stack Execution Stage

This block is the execute stage of a stack-oriented microcode engine. The two uppermost operand-stack values are kept in dedicated registers, called top and next here. Every deeper value sits in an on-chip stack memory, and the same memory also holds the local variables of the running method. A microinstruction enters through the decode inputs and is held in one pipeline register. The memory read it needs is started in that decode cycle, so the refill value is already waiting when the instruction executes in the following cycle. No instruction ever stalls, and no write-back stage follows execute.

The stage handles immediate push, pop, duplicate, five two-operand ALU operations, loading a local onto the stack, storing the top into a local, and loading the local-variable base pointer from the top. The memory pointer `sp` addresses the highest occupied memory word, the one just below next. Moving stack contents to and from main memory is left to microcode and is not done here.

Top module: `stkx_exec`

## Requirements
- R1: While `rst_n` is low and after its release, `tos_o` and `nos_o` read 0, `sp_o` reads `SP_INIT` (32 by default) and `vp_o` reads 0.
- R2: An instruction driven on the decode inputs before rising edge k changes the outputs at edge k+1. A new instruction is accepted at every edge, with no wait states.
- R3: Push (code 1) sets top to `imm_i` and next to the old top. It stores the old next at memory word `sp+1` and increments `sp`.
- R4: Pop (code 2) moves next into top, reloads next from memory word `sp` and decrements `sp`.
- R5: Duplicate (code 3) copies top into next, stores the old next at `sp+1` and increments `sp`. Top is unchanged.
- R6: Add (4), subtract (5), and (6), or (7) and xor (8) compute next OP top, with subtract giving next minus top, modulo 2^32. The result goes to top, next is reloaded from memory word `sp`, and `sp` is decremented.
- R7: Load-local (code 9) pushes memory word `vp + idx_i` onto the stack, with the same next, memory and `sp` updates as a push. `idx_i` is a 5-bit zero-extended index.
- R8: Store-local (code 10) writes top into memory word `vp + idx_i`, then pops as in R4.
- R9: Set-base (code 11) loads `vp` with the low address bits of top, then pops. A local access in the very next cycle already uses the new base.
- R10: Code 0 and the undefined codes 12 to 15 change none of top, next, `sp` or `vp`.
- R11: Consecutive instructions give the same results as isolated ones. A load-local right after a store to the same local returns the stored value, and a pop right after a push restores the pre-push next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Microinstruction code in the decode cycle |
| imm_i | input | 32 | Push immediate, taken with `op_i` |
| idx_i | input | 5 | Local-variable index, taken with `op_i` |
| tos_o | output | 32 | Top-of-stack register |
| nos_o | output | 32 | Next-on-stack register |
| sp_o | output | 8 | Address of the highest occupied memory word |
| vp_o | output | 8 | Local-variable base address |

## Verification
The hardest case is a memory read issued in decode that targets the word being written by the instruction in execute during that same cycle. This happens when a pop follows a push, or a load-local follows a store to the same local. A timing slip there returns stale data only under back-to-back issue. The bench therefore feeds such pairs on consecutive edges with no idle cycle between them. It also checks mid-stream on every cycle of a push burst, so that the one-instruction-per-cycle latency is pinned to the exact edge.

// File: rtl/stkx_pkg.sv
package stkx_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_PUSH  = 4'd1,
    OP_POP   = 4'd2,
    OP_DUP   = 4'd3,
    OP_ADD   = 4'd4,
    OP_SUB   = 4'd5,
    OP_AND   = 4'd6,
    OP_OR    = 4'd7,
    OP_XOR   = 4'd8,
    OP_LDL   = 4'd9,
    OP_STL   = 4'd10,
    OP_SETVP = 4'd11
  } stk_op_e;

  // instruction adds one element to the stack
  function automatic logic op_grows(stk_op_e op);
    return (op == OP_PUSH) || (op == OP_DUP) || (op == OP_LDL);
  endfunction

  // instruction removes one element and refills next from memory
  function automatic logic op_shrinks(stk_op_e op);
    return (op == OP_POP) || (op == OP_ADD) || (op == OP_SUB) ||
           (op == OP_AND) || (op == OP_OR)  || (op == OP_XOR) ||
           (op == OP_STL) || (op == OP_SETVP);
  endfunction

  function automatic logic op_is_alu(stk_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_XOR);
  endfunction

endpackage

// File: rtl/stkx_alu.sv
module stkx_alu
  import stkx_pkg::*;
#(
  parameter int DW = 32
) (
  input  stk_op_e       op,
  input  logic [DW-1:0] lhs,   // next
  input  logic [DW-1:0] rhs,   // top
  output logic [DW-1:0] res
);

  always_comb begin
    unique case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      default: res = rhs;
    endcase
  end

endmodule

// File: rtl/stkx_ram.sv
module stkx_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_d;

  // write-first: a read of the word written at the same edge sees the new value
  always_comb begin
    rdata_d = mem[raddr];
    if (we && (waddr == raddr)) rdata_d = wdata;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/stkx_ptr.sv
module stkx_ptr
  import stkx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int IDXW = 5
) (
  // instruction in execute
  input  stk_op_e         ex_op,
  input  logic [IDXW-1:0] ex_idx,
  // instruction in decode
  input  stk_op_e         dec_op,
  input  logic [IDXW-1:0] dec_idx,
  // current state
  input  logic [AW-1:0]   sp_q,
  input  logic [AW-1:0]   vp_q,
  input  logic [DW-1:0]   tos_q,
  input  logic [DW-1:0]   nos_q,
  // next state
  output logic [AW-1:0]   sp_d,
  output logic [AW-1:0]   vp_d,
  // memory control
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr
);

  logic [AW-1:0] sp_up;
  logic [AW-1:0] ex_loc;

  assign sp_up  = sp_q + AW'(1);
  assign ex_loc = vp_q + AW'(ex_idx);

  always_comb begin
    sp_d = sp_q;
    if (op_grows(ex_op))        sp_d = sp_up;
    else if (op_shrinks(ex_op)) sp_d = sp_q - AW'(1);
  end

  always_comb begin
    vp_d = vp_q;
    if (ex_op == OP_SETVP) vp_d = tos_q[AW-1:0];
  end

  // write port, used by the instruction in execute
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = sp_up;
    wr_data = nos_q;
    if (ex_op == OP_STL) begin
      wr_en   = 1'b1;
      wr_addr = ex_loc;
      wr_data = tos_q;
    end else if (op_grows(ex_op)) begin
      wr_en   = 1'b1;
    end
  end

  // read port, addressed one cycle ahead from the decoded instruction
  always_comb begin
    rd_en   = op_shrinks(dec_op) || (dec_op == OP_LDL);
    rd_addr = sp_d;
    if (dec_op == OP_LDL) rd_addr = vp_d + AW'(dec_idx);
  end

endmodule

// File: rtl/stkx_exec.sv
module stkx_exec
  import stkx_pkg::*;
#(
  parameter int DW      = 32,
  parameter int DEPTH   = 256,
  parameter int IDXW    = 5,
  parameter int SP_INIT = 32,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op_i,
  input  logic [DW-1:0]   imm_i,
  input  logic [IDXW-1:0] idx_i,
  output logic [DW-1:0]   tos_o,
  output logic [DW-1:0]   nos_o,
  output logic [AW-1:0]   sp_o,
  output logic [AW-1:0]   vp_o
);

  stk_op_e         dec_op;
  stk_op_e         ex_op_q;
  logic [DW-1:0]   ex_imm_q;
  logic [IDXW-1:0] ex_idx_q;

  logic [DW-1:0]   tos_q, tos_d;
  logic [DW-1:0]   nos_q, nos_d;
  logic [AW-1:0]   sp_q, sp_d;
  logic [AW-1:0]   vp_q, vp_d;
  logic            stk_en;

  logic            wr_en, rd_en;
  logic [AW-1:0]   wr_addr, rd_addr;
  logic [DW-1:0]   wr_data, rd_data;
  logic [DW-1:0]   alu_y;

  // undefined codes decode to no-op
  always_comb begin
    dec_op = OP_NOP;
    if (op_i <= 4'd11) dec_op = stk_op_e'(op_i);
  end

  // decode -> execute register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_op_q  <= OP_NOP;
      ex_imm_q <= '0;
      ex_idx_q <= '0;
    end else begin
      ex_op_q  <= dec_op;
      ex_imm_q <= imm_i;
      ex_idx_q <= idx_i;
    end
  end

  stkx_ptr #(.DW(DW), .AW(AW), .IDXW(IDXW)) ptr_i (
    .ex_op   (ex_op_q),
    .ex_idx  (ex_idx_q),
    .dec_op  (dec_op),
    .dec_idx (idx_i),
    .sp_q    (sp_q),
    .vp_q    (vp_q),
    .tos_q   (tos_q),
    .nos_q   (nos_q),
    .sp_d    (sp_d),
    .vp_d    (vp_d),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr)
  );

  stkx_ram #(.DW(DW), .DEPTH(DEPTH)) ram_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  stkx_alu #(.DW(DW)) alu_i (
    .op  (ex_op_q),
    .lhs (nos_q),
    .rhs (tos_q),
    .res (alu_y)
  );

  // next state of the register-held stack top
  always_comb begin
    tos_d = tos_q;
    nos_d = nos_q;
    unique case (ex_op_q)
      OP_PUSH: begin tos_d = ex_imm_q; nos_d = tos_q; end
      OP_DUP:  begin                   nos_d = tos_q; end
      OP_LDL:  begin tos_d = rd_data;  nos_d = tos_q; end
      OP_POP, OP_STL, OP_SETVP:
               begin tos_d = nos_q;    nos_d = rd_data; end
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR:
               begin tos_d = alu_y;    nos_d = rd_data; end
      default: ;
    endcase
  end

  assign stk_en = (ex_op_q != OP_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q <= '0;
      nos_q <= '0;
      sp_q  <= AW'(SP_INIT);
      vp_q  <= '0;
    end else if (stk_en) begin
      tos_q <= tos_d;
      nos_q <= nos_d;
      sp_q  <= sp_d;
      vp_q  <= vp_d;
    end
  end

  assign tos_o = tos_q;
  assign nos_o = nos_q;
  assign sp_o  = sp_q;
  assign vp_o  = vp_q;

endmodule

// File: rtl/stkx_exec_chk.sv
module stkx_exec_chk
  import stkx_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input stk_op_e       ex_op,
  input logic [DW-1:0] tos,
  input logic [DW-1:0] nos,
  input logic [AW-1:0] sp,
  input logic [AW-1:0] vp
);

  assert_grow_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_op == OP_PUSH || ex_op == OP_DUP || ex_op == OP_LDL) |=> sp == $past(sp) + AW'(1));

  assert_grow_nos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_op == OP_PUSH || ex_op == OP_DUP || ex_op == OP_LDL) |=> nos == $past(tos));

  assert_pop_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_op == OP_POP || ex_op == OP_STL || ex_op == OP_SETVP) |=>
      (tos == $past(nos)) && (sp == $past(sp) - AW'(1)));

  assert_setvp_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_op == OP_SETVP) |=> vp == $past(tos[AW-1:0]));

  assert_nop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_op == OP_NOP) |=> $stable(tos) && $stable(nos) && $stable(sp) && $stable(vp));

  assert_alu_shrink_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_op == OP_ADD || ex_op == OP_SUB || ex_op == OP_AND || ex_op == OP_OR || ex_op == OP_XOR)
      |=> sp == $past(sp) - AW'(1));

endmodule

bind stkx_exec stkx_exec_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .ex_op (ex_op_q),
  .tos   (tos_q),
  .nos   (nos_q),
  .sp    (sp_q),
  .vp    (vp_q)
);

// File: tb/stkx_exec_tb_top.sv
module stkx_exec_tb_top;

  localparam int DW = 32;
  localparam int DEPTH = 256;
  localparam int AW = 8;
  localparam int SP0 = 32;

  logic          clk;
  logic          rst_n;
  logic [3:0]    op_i;
  logic [DW-1:0] imm_i;
  logic [4:0]    idx_i;
  logic [DW-1:0] tos_o, nos_o;
  logic [AW-1:0] sp_o, vp_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference stack model
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_tos, m_nos;
  logic [AW-1:0] m_sp, m_vp;

  stkx_exec #(.DW(DW), .DEPTH(DEPTH), .IDXW(5), .SP_INIT(SP0)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i), .idx_i(idx_i),
    .tos_o(tos_o), .nos_o(nos_o), .sp_o(sp_o), .vp_o(vp_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic model(input logic [3:0] op, input logic [DW-1:0] imm, input logic [4:0] idx);
    logic [AW-1:0] loc;
    loc = m_vp + AW'(idx);
    case (op)
      4'd1, 4'd3, 4'd9: begin
        m_mem[m_sp + AW'(1)] = m_nos;
        m_nos = m_tos;
        m_tos = (op == 4'd1) ? imm : (op == 4'd9) ? m_mem[loc] : m_tos;
        m_sp  = m_sp + AW'(1);
      end
      4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10, 4'd11: begin
        case (op)
          4'd4:  m_tos = m_nos + m_tos;
          4'd5:  m_tos = m_nos - m_tos;
          4'd6:  m_tos = m_nos & m_tos;
          4'd7:  m_tos = m_nos | m_tos;
          4'd8:  m_tos = m_nos ^ m_tos;
          4'd10: begin m_mem[loc] = m_tos; m_tos = m_nos; end
          4'd11: begin m_vp = m_tos[AW-1:0]; m_tos = m_nos; end
          default: m_tos = m_nos;
        endcase
        m_nos = m_mem[m_sp];
        m_sp  = m_sp - AW'(1);
      end
      default: ;
    endcase
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic issue(input logic [3:0] op, input logic [DW-1:0] imm = '0, input logic [4:0] idx = '0);
    op_i = op; imm_i = imm; idx_i = idx;
    model(op, imm, idx);
    @(negedge clk);
    op_i = 4'd0; imm_i = '0; idx_i = '0;
  endtask

  task automatic drain();
    issue(4'd0); issue(4'd0);
  endtask

  task automatic chk_state(input string req);
    n_chk++;
    if (tos_o !== m_tos || nos_o !== m_nos || sp_o !== m_sp || vp_o !== m_vp) begin
      n_bad++;
      $display("FAIL %s: got tos=%h nos=%h sp=%0d vp=%0d expected tos=%h nos=%h sp=%0d vp=%0d",
               req, tos_o, nos_o, sp_o, vp_o, m_tos, m_nos, m_sp, m_vp);
    end
  endtask

  task automatic chk_val(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    op_i = 4'd0; imm_i = '0; idx_i = '0;
    m_tos = '0; m_nos = '0; m_sp = AW'(SP0); m_vp = '0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk_state("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 after release");
  endtask

  // R2 and R3: burst of pushes, checked on every cycle
  task automatic t_push_burst();
    logic [DW-1:0] v [5];
    logic [AW-1:0] base;
    base = sp_o;
    for (int i = 0; i < 5; i++) v[i] = 32'hA000_0000 + DW'(i * 17);
    issue(4'd1, v[0]);
    for (int i = 1; i < 5; i++) begin
      issue(4'd1, v[i]);
      chk_val("R2 mid-burst top", tos_o, v[i-1]);
      chk_val("R2 mid-burst sp", DW'(sp_o), DW'(base + AW'(i)));
    end
    drain();
    chk_state("R3 push burst final");
  endtask

  task automatic t_dup_pop();
    issue(4'd3); drain();
    chk_state("R5 dup");
    issue(4'd2); drain();
    chk_state("R4 pop after dup");
    issue(4'd2); issue(4'd2); drain();
    chk_state("R4 pops refill next from memory");
  endtask

  task automatic t_alu();
    for (int op = 4; op <= 8; op++) begin
      issue(4'd1, 32'h0000_0F35 + DW'(op));
      issue(4'd1, 32'h0000_1234 * DW'(op));
      issue(4'(op));
      drain();
      chk_state($sformatf("R6 alu code %0d", op));
    end
    issue(4'd1, 32'd3); issue(4'd1, 32'd10); issue(4'd5); drain();
    chk_val("R6 subtract wraps", tos_o, 32'hFFFF_FFF9);
  endtask

  task automatic t_locals();
    issue(4'd1, 32'd100); issue(4'd11); drain();
    chk_state("R9 set base");
    issue(4'd1, 32'h1111_0003); issue(4'd10, '0, 5'd3);
    issue(4'd1, 32'h2222_001F); issue(4'd10, '0, 5'd31);
    drain();
    chk_state("R8 store locals");
    issue(4'd9, '0, 5'd3); issue(4'd9, '0, 5'd31); drain();
    chk_state("R7 load locals");
    chk_val("R7 loaded local 31", tos_o, 32'h2222_001F);
    // new base used by the very next instruction
    issue(4'd1, 32'd97); issue(4'd11); issue(4'd9, '0, 5'd6); drain();
    chk_val("R9 new base used at once", tos_o, 32'h1111_0003);
    chk_state("R9 base then load");
    issue(4'd2); issue(4'd2); issue(4'd2); drain();
  endtask

  task automatic t_back_to_back();
    issue(4'd1, 32'h5555_AAAA); issue(4'd10, '0, 5'd12); issue(4'd9, '0, 5'd12); drain();
    chk_val("R11 store then load", tos_o, 32'h5555_AAAA);
    chk_state("R11 store then load state");
    issue(4'd1, 32'hBEEF_0001); issue(4'd2); drain();
    chk_state("R11 push then pop");
    issue(4'd1, 32'd7); issue(4'd1, 32'd9); issue(4'd4); issue(4'd3); issue(4'd6); issue(4'd2); drain();
    chk_state("R11 mixed stream");
  endtask

  task automatic t_nop();
    issue(4'd0); issue(4'd12); issue(4'd14); issue(4'd15); drain();
    chk_state("R10 no-op and undefined codes");
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    // seed the stack so no read touches unwritten memory
    for (int i = 0; i < 4; i++) issue(4'd1, 32'hC0DE_0000 + DW'(i));
    drain();
    t_push_burst();
    t_dup_pop();
    t_alu();
    t_locals();
    t_back_to_back();
    t_nop();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule